// File: doc/BRIEF.md
# Four-Level Page-Table Walker

This block turns a 48-bit virtual address into a physical address. It reads a four-level tree of translation tables that sits in memory. A request carries the virtual address and a 64-bit root value. The root holds the base of the top-level table and two cache attribute bits. The walker then makes one 8-byte read per level through a memory read port. Each read uses the table base from the previous step together with a 9-bit slice of the virtual address.

A walk ends in one of three ways. A fourth-level entry maps a 4 KB page. A third-level entry with its page-size bit set maps a 2 MB page. Otherwise the walk stops with a fault that reports its cause and its level. The parameter `PHYS_W` sets how many physical address bits are implemented; any higher bit that is set, up to bit 51, is treated as reserved. The walker handles one translation at a time. It takes a new request only after the previous response has been accepted.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_req_valid` are 0.
- R2: If bits 63:47 of the virtual address are not all equal, the response has fault code 3 (non-canonical) and level 0. No memory read is issued.
- R3: A canonical request whose root has any bit in 63:PHYS_W set gets fault code 2 (reserved) at level 0. No memory read is issued.
- R4: The first read address is root bits 51:12, then virtual address bits 47:39, then three zero bits.
- R5: Each later read address is bits 51:12 of the previous entry, then the next 9-bit slice of the virtual address, then three zero bits. The slices are bits 38:30, 29:21 and 20:12, in that order.
- R6: If an entry has bit 0 (present) clear, the walk stops with fault code 1 and the level number of that entry. The levels are numbered 0 (top) to 3. On any fault the physical address and the 2 MB flag are 0.
- R7: If a present entry has any bit in 51:PHYS_W set, the walk stops with fault code 2 and the level number of that entry.
- R8: If the level-2 entry has bit 7 set, the walk ends after three reads. The response has fault code 0, the 2 MB flag set to 1, and a physical address made of entry bits 51:21 followed by virtual address bits 20:0.
- R9: Otherwise the walk makes four reads. The response has fault code 0, the 2 MB flag set to 0, and a physical address made of level-3 entry bits 51:12 followed by virtual address bits 11:0. Bit 7 in the entries of levels 0, 1 and 3 has no effect.
- R10: `rsp_pwt` is root bit 3 and `rsp_pcd` is root bit 4. Root bits 2:0 and 11:5 have no effect on any read address or on any result.
- R11: Once `mem_req_valid` is raised, it stays high with a stable address until `mem_req_ready` is accepted. At most one read is outstanding. A response holds its value until `rsp_ready` is accepted. `req_ready` is high only when no read and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and accepting a request |
| req_vaddr | input | 64 | Virtual address to translate |
| req_root | input | 64 | Root pointer: table base in 51:12, attribute bits 3 and 4 |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 52 | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Read data valid (the walker always takes it while waiting) |
| mem_rsp_data | input | 64 | Entry contents |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer accepts the result |
| rsp_paddr | output | 52 | Physical address (0 on fault) |
| rsp_is_2m | output | 1 | 1 when a 2 MB page was mapped |
| rsp_pwt | output | 1 | Write-through attribute from root bit 3 |
| rsp_pcd | output | 1 | Cache-disable attribute from root bit 4 |
| rsp_fault | output | 2 | 0 none, 1 not present, 2 reserved bit, 3 non-canonical |
| rsp_fault_level | output | 2 | Level of the faulting check, 0 (top) to 3 |

## Verification
The assertions assume three things about the memory side. `mem_rsp_valid` is raised only while a read is outstanding, that is, after the request handshake and before the data returns. It is raised once per read. The request inputs are sampled only in the cycle in which `req_ready` is high.

The bench enforces these rules itself. It plays the memory as a sequential responder that returns exactly one entry for each accepted read, after a latency of zero to two cycles. It holds `req_valid` only until the first handshake. It sweeps every fault kind at every level, plus both page sizes, over sixteen address and root patterns. It varies the ready stalls and the response back-pressure in each run.

// File: rtl/pt_walker_pkg.sv
// Shared constants, encodings and helpers for the page-table walker.
// Assumes the architectural physical address limit of 52 bits.
package pt_walker_pkg;
    localparam int ADDR_MAX    = 52;  // widest physical address
    localparam int ENTRY_W     = 64;  // bits per table entry
    localparam int PAGE_SHIFT  = 12;  // 4 KB page / table alignment
    localparam int LARGE_SHIFT = 21;  // 2 MB page alignment
    localparam int PS_BIT      = 7;   // page-size flag in an entry
    localparam int PRESENT_BIT = 0;   // present flag in an entry
    localparam int PWT_BIT     = 3;   // root write-through attribute
    localparam int PCD_BIT     = 4;   // root cache-disable attribute
    localparam int BASE_W      = ADDR_MAX - PAGE_SHIFT;

    typedef enum logic [1:0] {
        FLT_NONE        = 2'd0,
        FLT_NOT_PRESENT = 2'd1,
        FLT_RESERVED    = 2'd2,
        FLT_NONCANON    = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } state_e;

    // Mask with bits lo..hi-1 set.
    function automatic logic [ENTRY_W-1:0] bit_range(input int lo, input int hi);
        logic [ENTRY_W-1:0] m;
        m = '0;
        for (int i = 0; i < ENTRY_W; i++) begin
            if (i >= lo && i < hi) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/pt_req_check.sv
// Request screening: the virtual address must be a sign extension of bit VA_W-1,
// and the root must have no bits set at or above PHYS_W.
// Assumes PHYS_W <= 52 and VA_W < 64.
module pt_req_check
    import pt_walker_pkg::*;
#(
    parameter int VA_W   = 48,
    parameter int PHYS_W = 52
) (
    input  logic [ENTRY_W-1:0] vaddr,
    input  logic [ENTRY_W-1:0] root,
    output logic               canon_ok,
    output logic               root_ok
);
    localparam logic [ENTRY_W-1:0] ROOT_RESV = bit_range(PHYS_W, ENTRY_W);

    logic [ENTRY_W-VA_W:0] upper;

    // Sign-extension and root reserved-bit screening.
    always_comb begin
        upper    = vaddr[ENTRY_W-1:VA_W-1];
        canon_ok = (&upper) | ~(|upper);
        root_ok  = ~(|(root & ROOT_RESV));
    end
endmodule

// File: rtl/pt_addr_gen.sv
// Entry address builder: joins a table base with the index slice chosen by the
// current level and three zero bits. Level 0 uses the highest slice.
// Assumes LEVELS * IDX_W + PAGE_SHIFT == VA_W.
module pt_addr_gen
    import pt_walker_pkg::*;
#(
    parameter int VA_W   = 48,
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic [BASE_W-1:0]   base,
    input  logic [VA_W-1:0]     vaddr,
    input  logic [LVL_W-1:0]    level,
    output logic [ADDR_MAX-1:0] addr
);
    localparam int OFS_W = PAGE_SHIFT - IDX_W;

    logic [IDX_W-1:0] slice [LEVELS];
    logic [PAGE_SHIFT-1:0] unused_low;

    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign slice[g] = vaddr[VA_W-1-IDX_W*g -: IDX_W];
    end

    assign unused_low = vaddr[PAGE_SHIFT-1:0];

    // Concatenate base, level index and byte offset of an 8-byte entry.
    always_comb begin
        addr = {base, slice[level], {OFS_W{1'b0}}};
    end
endmodule

// File: rtl/pt_entry_check.sv
// Entry decoder: present flag, reserved physical bits, leaf detection and the
// next table base or final physical address.
// Assumes level LEVELS-2 may hold a 2 MB leaf and level LEVELS-1 is always a leaf.
module pt_entry_check
    import pt_walker_pkg::*;
#(
    parameter int VA_W   = 48,
    parameter int PHYS_W = 52,
    parameter int LEVELS = 4,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic [ENTRY_W-1:0]  entry,
    input  logic [LVL_W-1:0]    level,
    input  logic [VA_W-1:0]     vaddr,
    output logic                present,
    output logic                resv_bad,
    output logic                leaf,
    output logic                is_2m,
    output logic [BASE_W-1:0]   next_base,
    output logic [ADDR_MAX-1:0] leaf_paddr
);
    localparam logic [ENTRY_W-1:0] ENT_RESV  = bit_range(PHYS_W, ADDR_MAX);
    localparam logic [LVL_W-1:0]   LEAF_LVL  = LVL_W'(LEVELS - 1);
    localparam logic [LVL_W-1:0]   LARGE_LVL = LVL_W'(LEVELS - 2);

    logic [VA_W-1:LARGE_SHIFT] unused_va;
    assign unused_va = vaddr[VA_W-1:LARGE_SHIFT];

    // Decode one fetched entry against its level.
    always_comb begin
        present   = entry[PRESENT_BIT];
        resv_bad  = |(entry & ENT_RESV);
        is_2m     = (level == LARGE_LVL) && entry[PS_BIT];
        leaf      = is_2m || (level == LEAF_LVL);
        next_base = entry[ADDR_MAX-1:PAGE_SHIFT];
        if (is_2m)
            leaf_paddr = {entry[ADDR_MAX-1:LARGE_SHIFT], vaddr[LARGE_SHIFT-1:0]};
        else
            leaf_paddr = {entry[ADDR_MAX-1:PAGE_SHIFT], vaddr[PAGE_SHIFT-1:0]};
    end
endmodule

// File: rtl/pt_walker.sv
// Four-level page-table walker. Accepts one request, screens it, issues one
// entry read per level with a single outstanding read, and returns either a
// 4 KB or 2 MB translation or a fault with its level.
// Assumes memory raises mem_rsp_valid once per accepted read, only in ST_WAIT.
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int VA_W   = 48,
    parameter int PHYS_W = 52,
    parameter int LEVELS = 4,
    parameter int IDX_W  = 9,
    localparam int LVL_W = $clog2(LEVELS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ENTRY_W-1:0]  req_vaddr,
    input  logic [ENTRY_W-1:0]  req_root,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [ADDR_MAX-1:0] mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [ENTRY_W-1:0]  mem_rsp_data,
    output logic                rsp_valid,
    input  logic                rsp_ready,
    output logic [ADDR_MAX-1:0] rsp_paddr,
    output logic                rsp_is_2m,
    output logic                rsp_pwt,
    output logic                rsp_pcd,
    output logic [1:0]          rsp_fault,
    output logic [LVL_W-1:0]    rsp_fault_level
);
    state_e                state_q;
    logic [VA_W-1:0]       vaddr_q;
    logic [BASE_W-1:0]     base_q;
    logic [LVL_W-1:0]      level_q;
    logic [ADDR_MAX-1:0]   paddr_q;
    logic                  is_2m_q;
    logic                  pwt_q;
    logic                  pcd_q;
    fault_e                fault_q;
    logic [LVL_W-1:0]      flvl_q;

    logic                  canon_ok;
    logic                  root_ok;
    logic                  ent_present;
    logic                  ent_resv;
    logic                  ent_leaf;
    logic                  ent_2m;
    logic [BASE_W-1:0]     ent_next_base;
    logic [ADDR_MAX-1:0]   ent_paddr;

    pt_req_check #(.VA_W(VA_W), .PHYS_W(PHYS_W)) u_req_check (
        .vaddr    (req_vaddr),
        .root     (req_root),
        .canon_ok (canon_ok),
        .root_ok  (root_ok)
    );

    pt_addr_gen #(.VA_W(VA_W), .LEVELS(LEVELS), .IDX_W(IDX_W)) u_addr_gen (
        .base  (base_q),
        .vaddr (vaddr_q),
        .level (level_q),
        .addr  (mem_req_addr)
    );

    pt_entry_check #(.VA_W(VA_W), .PHYS_W(PHYS_W), .LEVELS(LEVELS)) u_entry_check (
        .entry      (mem_rsp_data),
        .level      (level_q),
        .vaddr      (vaddr_q),
        .present    (ent_present),
        .resv_bad   (ent_resv),
        .leaf       (ent_leaf),
        .is_2m      (ent_2m),
        .next_base  (ent_next_base),
        .leaf_paddr (ent_paddr)
    );

    // Walk sequencing and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vaddr_q <= '0;
            base_q  <= '0;
            level_q <= '0;
            paddr_q <= '0;
            is_2m_q <= 1'b0;
            pwt_q   <= 1'b0;
            pcd_q   <= 1'b0;
            fault_q <= FLT_NONE;
            flvl_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        vaddr_q <= req_vaddr[VA_W-1:0];
                        base_q  <= req_root[ADDR_MAX-1:PAGE_SHIFT];
                        pwt_q   <= req_root[PWT_BIT];
                        pcd_q   <= req_root[PCD_BIT];
                        level_q <= '0;
                        paddr_q <= '0;
                        is_2m_q <= 1'b0;
                        flvl_q  <= '0;
                        if (!canon_ok) begin
                            fault_q <= FLT_NONCANON;
                            state_q <= ST_RESP;
                        end else if (!root_ok) begin
                            fault_q <= FLT_RESERVED;
                            state_q <= ST_RESP;
                        end else begin
                            fault_q <= FLT_NONE;
                            state_q <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_req_ready) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!ent_present) begin
                            fault_q <= FLT_NOT_PRESENT;
                            flvl_q  <= level_q;
                            state_q <= ST_RESP;
                        end else if (ent_resv) begin
                            fault_q <= FLT_RESERVED;
                            flvl_q  <= level_q;
                            state_q <= ST_RESP;
                        end else if (ent_leaf) begin
                            paddr_q <= ent_paddr;
                            is_2m_q <= ent_2m;
                            state_q <= ST_RESP;
                        end else begin
                            base_q  <= ent_next_base;
                            level_q <= level_q + LVL_W'(1);
                            state_q <= ST_FETCH;
                        end
                    end
                end
                ST_RESP: begin
                    if (rsp_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Handshake outputs and registered result.
    always_comb begin
        req_ready       = (state_q == ST_IDLE);
        mem_req_valid   = (state_q == ST_FETCH);
        rsp_valid       = (state_q == ST_RESP);
        rsp_paddr       = paddr_q;
        rsp_is_2m       = is_2m_q;
        rsp_pwt         = pwt_q;
        rsp_pcd         = pcd_q;
        rsp_fault       = fault_q;
        rsp_fault_level = flvl_q;
    end
endmodule

// File: rtl/pt_walker_chk.sv
// Protocol and ordering checks for pt_walker, attached with bind.
// Assumes mem_rsp_valid only follows an accepted read.
module pt_walker_chk
    import pt_walker_pkg::*;
#(
    parameter int VA_W   = 48,
    parameter int PHYS_W = 52,
    parameter int LEVELS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic [ENTRY_W-1:0]  req_vaddr,
    input logic [ENTRY_W-1:0]  req_root,
    input logic                mem_req_valid,
    input logic                mem_req_ready,
    input logic [ADDR_MAX-1:0] mem_req_addr,
    input logic                rsp_valid,
    input logic                rsp_ready,
    input logic [ADDR_MAX-1:0] rsp_paddr,
    input logic [1:0]          rsp_fault
);
    logic accept;
    logic va_canon;
    logic root_clean;
    int   fcnt;

    assign accept     = req_valid && req_ready;
    assign va_canon   = (&req_vaddr[ENTRY_W-1:VA_W-1]) || !(|req_vaddr[ENTRY_W-1:VA_W-1]);
    assign root_clean = ((req_root >> PHYS_W) == '0);

    // Count reads issued in the current walk.
    always_ff @(posedge clk) begin
        if (!rst_n)                          fcnt <= 0;
        else if (accept)                     fcnt <= 0;
        else if (mem_req_valid && mem_req_ready) fcnt <= fcnt + 1;
    end

    AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R11
    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)); // R11
    AST_IDLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid && !rsp_valid); // R11
    AST_CANON_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !va_canon |=> !mem_req_valid && rsp_valid && rsp_fault == 2'd3); // R2
    AST_ROOT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        accept && va_canon && !root_clean |=> !mem_req_valid && rsp_valid && rsp_fault == 2'd2); // R3
    AST_TOP_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        accept && va_canon && root_clean |=> mem_req_valid &&
        mem_req_addr == $past({req_root[ADDR_MAX-1:PAGE_SHIFT], req_vaddr[VA_W-1 -: 9], 3'b000})); // R4
    AST_ADDR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[2:0] == 3'b000); // R5
    AST_FETCH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> fcnt < LEVELS); // R9
    AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault != 2'd0 |-> rsp_paddr == '0); // R6
endmodule

bind pt_walker pt_walker_chk #(.VA_W(VA_W), .PHYS_W(PHYS_W), .LEVELS(LEVELS)) u_pt_walker_chk (.*);

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
    localparam int PW = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic [63:0] req_root = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [51:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [51:0] rsp_paddr;
    logic        rsp_is_2m;
    logic        rsp_pwt;
    logic        rsp_pcd;
    logic [1:0]  rsp_fault;
    logic [1:0]  rsp_fault_level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [63:0] ent [4];

    always #4 clk = ~clk;

    pt_walker #(.PHYS_W(PW)) i_pt_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_root(req_root),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_paddr(rsp_paddr), .rsp_is_2m(rsp_is_2m),
        .rsp_pwt(rsp_pwt), .rsp_pcd(rsp_pcd),
        .rsp_fault(rsp_fault), .rsp_fault_level(rsp_fault_level)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_walk(input logic [63:0] va, input logic [63:0] root,
                            input int stall, input int lat, input bit hold, input string tag);
        int          exp_n;
        logic [1:0]  exp_code;
        logic [1:0]  exp_lvl;
        logic [51:0] exp_pa;
        logic        exp_2m;
        int          nf;
        int          guard;
        logic [39:0] base;
        logic [8:0]  idx;
        logic [51:0] eaddr;
        logic [51:0] held;
        // model from the requirements
        exp_n = 0; exp_code = 2'd0; exp_lvl = 2'd0; exp_pa = '0; exp_2m = 1'b0;
        if (!((&va[63:47]) || !(|va[63:47]))) exp_code = 2'd3;
        else if ((root >> PW) != 0) exp_code = 2'd2;
        else begin
            for (int k = 0; k < 4; k++) begin
                exp_n = k + 1;
                if (!ent[k][0]) begin exp_code = 2'd1; exp_lvl = 2'(k); break; end
                if ((ent[k][51:0] >> PW) != 0) begin exp_code = 2'd2; exp_lvl = 2'(k); break; end
                if (k == 2 && ent[k][7]) begin exp_pa = {ent[k][51:21], va[20:0]}; exp_2m = 1'b1; break; end
                if (k == 3) exp_pa = {ent[k][51:12], va[11:0]};
            end
        end
        // issue request
        req_vaddr = va; req_root = root; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        nf = 0; guard = 0;
        while (!rsp_valid && guard < 80) begin
            if (mem_req_valid) begin
                base  = (nf == 0) ? root[51:12] : ent[(nf == 0) ? 0 : nf-1][51:12];
                idx   = 9'((va >> (39 - 9*nf)) & 64'h1FF);
                eaddr = {base, idx, 3'b000};
                chk(nf < 4, "R11 read count", 64'(nf), 64'd3);
                chk(mem_req_addr == eaddr, (nf == 0) ? "R4/R10 top address" : "R5 level address",
                    64'(mem_req_addr), 64'(eaddr));
                held = mem_req_addr;
                for (int s = 0; s < stall; s++) begin
                    @(negedge clk);
                    chk(mem_req_valid && mem_req_addr == held, "R11 request hold", 64'(mem_req_addr), 64'(held));
                end
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                for (int s = 0; s < lat; s++) begin
                    chk(!mem_req_valid, "R11 single outstanding", 64'(mem_req_valid), 64'd0);
                    @(negedge clk);
                end
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = ent[(nf > 3) ? 3 : nf];
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                nf++;
            end else begin
                @(negedge clk);
            end
            guard++;
        end
        chk(rsp_valid, {tag, " response seen"}, 64'(rsp_valid), 64'd1);
        chk(nf == exp_n, {tag, " read count"}, 64'(nf), 64'(exp_n));
        chk(rsp_fault == exp_code, {tag, " fault code"}, 64'(rsp_fault), 64'(exp_code));
        chk(rsp_fault_level == exp_lvl, {tag, " fault level"}, 64'(rsp_fault_level), 64'(exp_lvl));
        chk(rsp_paddr == exp_pa, {tag, " paddr"}, 64'(rsp_paddr), 64'(exp_pa));
        chk(rsp_is_2m == exp_2m, {tag, " 2MB flag"}, 64'(rsp_is_2m), 64'(exp_2m));
        chk(rsp_pwt == root[3] && rsp_pcd == root[4], "R10 attributes",
            64'({rsp_pcd, rsp_pwt}), 64'(root[4:3]));
        if (hold) begin
            @(negedge clk);
            chk(rsp_valid && rsp_paddr == exp_pa && rsp_fault == exp_code, "R11 response hold",
                64'(rsp_paddr), 64'(exp_pa));
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(req_ready && !rsp_valid, "R11 back to idle", 64'(req_ready), 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R1 reset state",
            64'({req_ready, rsp_valid, mem_req_valid}), 64'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_req_valid, "R1 after reset release",
            64'({req_ready, rsp_valid, mem_req_valid}), 64'b100);
        for (int p = 0; p < 16; p++) begin
            for (int kind = 0; kind < 12; kind++) begin
                logic [47:0] lo;
                logic [63:0] va;
                logic [63:0] root;
                logic [27:0] rb;
                string       tag;
                lo = 48'(p) * 48'h3579_BDF1_2468 + 48'(kind) * 48'h0000_1111_0001;
                lo[47] = p[0] ^ kind[0];
                va = {{16{lo[47]}}, lo};
                rb = 28'(p) * 28'h0123457 + 28'h0F0F0F1;
                root = {24'h0, rb, 12'(p * 12'h35B)};
                for (int k = 0; k < 4; k++) begin
                    logic [27:0] eb;
                    eb = 28'(p) * 28'h0123457 + 28'(k) * 28'h0ABCDE1 + 28'(kind) * 28'h31;
                    ent[k] = {12'hF5A, 12'h000, eb, 4'(p), 1'b0, 6'b010101, 1'b1};
                end
                tag = "R9 4KB";
                if (kind == 0 && p[0]) begin
                    ent[0][7] = 1'b1; ent[1][7] = 1'b1; ent[3][7] = 1'b1;
                end
                if (kind == 1) begin ent[2][7] = 1'b1; tag = "R8 2MB"; end
                if (kind >= 2 && kind <= 5) begin ent[kind-2][0] = 1'b0; tag = "R6 not present"; end
                if (kind >= 6 && kind <= 9) begin ent[kind-6][40 + (p % 12)] = 1'b1; tag = "R7 entry reserved"; end
                if (kind == 10) begin va[50] = ~va[50]; tag = "R2 non-canonical"; end
                if (kind == 11) begin root[PW + (p % 24)] = 1'b1; tag = "R3 root reserved"; end
                run_walk(va, root, p % 3, (p + kind) % 3, p[1], tag);
            end
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule